// File: doc/BRIEF.md
# Cascaded Interrupt Controller

This block gathers interrupt requests from two banks of level-sensitive sources and presents them to a CPU. It has a primary bank of 40 lines and a secondary bank of 32 lines. Every secondary source that is both latched and enabled feeds primary line 0. Each line has a pending latch and an enable bit. Software acknowledges a line by writing a one to a clear register. It enables and disables lines through separate set and clear registers, so a write only changes the bits written as one.

The CPU sees one active-high request output. It also sees a priority index register that names the lowest-numbered primary line above 0 that is pending and enabled. When that register reads 0, software looks at the secondary status word to find out whether the cascade line is the cause. A table of small channel-map registers, one per primary line, starts out holding the identity mapping and can be read and written.

The register bus is a plain 32-bit write/read port. Byte addresses are word aligned, and a write takes effect at the clock edge where it is presented. Read data is combinational from the address and the registered state.

Top module: `casc_intc`

## Requirements
- R1: After reset all pending bits and all enables of both banks are 0, `cpu_irq` is 0, the index register reads 0, and channel-map entry c reads c.
- R2: An asserted source sets its pending bit at the next clock edge, whether or not the line is enabled. The bit stays set after the source drops. Primary lines 0..31 read at 0x000 bit n. Lines 32..39 read at 0x004 bits 7:0. Secondary line n reads at 0x080 bit n.
- R3: Writing one to a bit clears that line's pending latch: primary lines 0..31 at 0x010, lines 32..39 at 0x014 bits 7:0, secondary lines at 0x088. Zero bits have no effect. The clear wins in the cycle it is written. A source that is still asserted sets the bit again at the following edge.
- R4: Writing one to a bit enables the line: primary at 0x020/0x024, secondary at 0x090. Writing one at 0x030/0x034 (primary) or 0x098 (secondary) disables it. Zero bits leave the enable unchanged. Enables read back at either the set or the clear address.
- R5: The source of primary line 0 is the OR of all secondary lines that are pending and enabled. It reaches primary pending bit 0 one clock after the secondary state that produces it.
- R6: The register at 0x040 returns, in bits 5:0, the lowest-numbered primary line in 1..39 that is pending and enabled, and 0 when there is none. Bits 31:6 read 0.
- R7: `cpu_irq` is 1 exactly when at least one primary line is both pending and enabled.
- R8: Channel-map entry c (c from 0 to 39) sits at 0x200 + 4*c and holds 6 bits. Upper bits read 0. Addresses past the last entry read 0 and ignore writes.
- R9: Bits 31:8 of the upper primary words (0x004, 0x014, 0x024, 0x034) read 0, and writes to them are ignored. Unmapped or unaligned addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pri_src | input | 39 | Level requests for primary lines 1..39 (bit n is line n) |
| sec_src | input | 32 | Level requests for secondary lines 0..31 |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| cpu_irq | output | 1 | Active-high interrupt request to the CPU |

## Verification
A software acknowledge and a still-asserted source can meet on the same pending bit in the same cycle. The bench provokes this by holding a source high while it writes that bit's clear register. It does so for a lower-word primary line, an upper-word primary line and a secondary line. The pending word is read right after the clear edge and must show the bit cleared; one cycle later it must show the bit set again. The bench also separates the secondary latch edge from the cascade edge on line 0, and checks that line 0 is still low in the intermediate cycle.

// File: rtl/casc_intc_pkg.sv
package casc_intc_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 12;
    localparam int CH_W   = 6;

    localparam logic [ADDR_W-1:0] OFS_INDEX  = 12'h040;
    localparam logic [ADDR_W-1:0] OFS_SSTAT  = 12'h080;
    localparam logic [ADDR_W-1:0] OFS_SACK   = 12'h088;
    localparam logic [ADDR_W-1:0] OFS_SENSET = 12'h090;
    localparam logic [ADDR_W-1:0] OFS_SENCLR = 12'h098;
    localparam logic [2:0]        MAP_PAGE   = 3'b001;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_PEND,
        SEL_ACK,
        SEL_ENSET,
        SEL_ENCLR,
        SEL_INDEX,
        SEL_SSTAT,
        SEL_SACK,
        SEL_SENSET,
        SEL_SENCLR,
        SEL_CHMAP
    } reg_sel_e;

endpackage

// File: rtl/intc_decode.sv
module intc_decode
    import casc_intc_pkg::*;
#(
    parameter int PRI_LINES = 40,
    localparam int CI_W = $clog2(PRI_LINES)
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic              hi_word,
    output logic [CI_W-1:0]   chan
);

    logic [ADDR_W-3:0] word;
    logic [6:0]        map_slot;

    always_comb begin
        word     = addr[ADDR_W-1:2];
        map_slot = addr[8:2];
        sel      = SEL_NONE;
        hi_word  = 1'b0;
        chan     = map_slot[CI_W-1:0];
        if (addr[1:0] == 2'b00) begin
            if (addr[ADDR_W-1:6] == '0 && addr[3] == 1'b0) begin
                hi_word = addr[2];
                case (addr[5:4])
                    2'd0:    sel = SEL_PEND;
                    2'd1:    sel = SEL_ACK;
                    2'd2:    sel = SEL_ENSET;
                    default: sel = SEL_ENCLR;
                endcase
            end else if (word == OFS_INDEX[ADDR_W-1:2]) begin
                sel = SEL_INDEX;
            end else if (word == OFS_SSTAT[ADDR_W-1:2]) begin
                sel = SEL_SSTAT;
            end else if (word == OFS_SACK[ADDR_W-1:2]) begin
                sel = SEL_SACK;
            end else if (word == OFS_SENSET[ADDR_W-1:2]) begin
                sel = SEL_SENSET;
            end else if (word == OFS_SENCLR[ADDR_W-1:2]) begin
                sel = SEL_SENCLR;
            end else if (addr[ADDR_W-1:9] == MAP_PAGE &&
                         int'(map_slot) < PRI_LINES) begin
                sel = SEL_CHMAP;
            end
        end
    end

endmodule

// File: rtl/intc_bank.sv
module intc_bank #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src,
    input  logic [N-1:0] ack,
    input  logic [N-1:0] en_set,
    input  logic [N-1:0] en_clr,
    output logic [N-1:0] pend,
    output logic [N-1:0] en
);

    typedef struct packed {
        logic [N-1:0] pend;
        logic [N-1:0] en;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d      = bank_q;
        bank_d.pend = (bank_q.pend | src) & ~ack;
        bank_d.en   = (bank_q.en | en_set) & ~en_clr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign pend = bank_q.pend;
    assign en   = bank_q.en;

    // R3: an acknowledged bit is low after the edge, even with its source high
    a_r3_ack_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack) |=> ((pend & $past(ack)) == '0));

    // R2: a source that is not being acknowledged is latched at the next edge
    a_r2_level_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (|(src & ~ack)) |=> ((pend & $past(src & ~ack)) == $past(src & ~ack)));

    // R4: set bits become enabled, clear bits become disabled
    a_r4_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
        (|(en_set & ~en_clr)) |=>
            ((en & $past(en_set & ~en_clr)) == $past(en_set & ~en_clr)));

    a_r4_enable_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (|en_clr) |=> ((en & $past(en_clr)) == '0));

endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
    parameter int N  = 40,
    parameter int IW = 6
) (
    input  logic [N-1:0]  req,
    output logic [IW-1:0] idx,
    output logic          any
);

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 1; i--) begin
            if (req[i]) idx = IW'(i);
        end
        any = |req;
    end

endmodule

// File: rtl/intc_chmap.sv
module intc_chmap #(
    parameter int N    = 40,
    parameter int CH_W = 6,
    localparam int CI_W = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [CI_W-1:0] idx,
    input  logic [CH_W-1:0] wdata,
    output logic [CH_W-1:0] rdata
);

    typedef logic [CH_W-1:0] map_t;

    map_t [N-1:0] map_d, map_q;

    always_comb begin
        map_d = map_q;
        if (we) map_d[idx] = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) map_q[i] <= CH_W'(i);
        end else begin
            map_q <= map_d;
        end
    end

    assign rdata = map_q[idx];

    // R8: a written entry holds the written value on the next cycle
    a_r8_map_write: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (map_q[$past(idx)] == $past(wdata)));

endmodule

// File: rtl/casc_intc.sv
module casc_intc
    import casc_intc_pkg::*;
#(
    parameter int PRI_LINES = 40,
    parameter int SEC_LINES = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PRI_LINES-1:1]  pri_src,
    input  logic [SEC_LINES-1:0]  sec_src,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [BUS_W-1:0]      bus_wdata,
    output logic [BUS_W-1:0]      bus_rdata,
    output logic                  cpu_irq
);

    localparam int HI_LINES = PRI_LINES - BUS_W;
    localparam int CI_W     = $clog2(PRI_LINES);

    reg_sel_e               sel;
    logic                   hi_word;
    logic [CI_W-1:0]        chan;

    logic [PRI_LINES-1:0]   wvec_pri;
    logic [PRI_LINES-1:0]   pri_src_all, pri_ack, pri_set, pri_clr;
    logic [PRI_LINES-1:0]   pri_pend, pri_en, pri_req;
    logic [SEC_LINES-1:0]   sec_ack, sec_set, sec_clr, sec_pend, sec_en;
    logic                   cascade;
    logic [CI_W-1:0]        prio_idx;
    logic                   prio_any;
    logic [CH_W-1:0]        map_rd;
    logic                   map_we;
    logic [BUS_W-1:0]       pend_word, en_word;

    intc_decode #(.PRI_LINES(PRI_LINES)) u_decode (
        .addr    (bus_addr),
        .sel     (sel),
        .hi_word (hi_word),
        .chan    (chan)
    );

    // Write vectors: the upper primary word carries only HI_LINES bits
    always_comb begin
        wvec_pri = '0;
        if (hi_word) wvec_pri[PRI_LINES-1:BUS_W] = bus_wdata[HI_LINES-1:0];
        else         wvec_pri[BUS_W-1:0]         = bus_wdata;
        pri_ack = (bus_wr && sel == SEL_ACK)    ? wvec_pri : '0;
        pri_set = (bus_wr && sel == SEL_ENSET)  ? wvec_pri : '0;
        pri_clr = (bus_wr && sel == SEL_ENCLR)  ? wvec_pri : '0;
        sec_ack = (bus_wr && sel == SEL_SACK)   ? bus_wdata[SEC_LINES-1:0] : '0;
        sec_set = (bus_wr && sel == SEL_SENSET) ? bus_wdata[SEC_LINES-1:0] : '0;
        sec_clr = (bus_wr && sel == SEL_SENCLR) ? bus_wdata[SEC_LINES-1:0] : '0;
        map_we  = bus_wr && sel == SEL_CHMAP;
    end

    intc_bank #(.N(SEC_LINES)) u_sec_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .src    (sec_src),
        .ack    (sec_ack),
        .en_set (sec_set),
        .en_clr (sec_clr),
        .pend   (sec_pend),
        .en     (sec_en)
    );

    assign cascade     = |(sec_pend & sec_en);
    assign pri_src_all = {pri_src, cascade};

    intc_bank #(.N(PRI_LINES)) u_pri_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .src    (pri_src_all),
        .ack    (pri_ack),
        .en_set (pri_set),
        .en_clr (pri_clr),
        .pend   (pri_pend),
        .en     (pri_en)
    );

    assign pri_req = pri_pend & pri_en;

    intc_prio #(.N(PRI_LINES), .IW(CI_W)) u_prio (
        .req (pri_req),
        .idx (prio_idx),
        .any (prio_any)
    );

    assign cpu_irq = prio_any;

    intc_chmap #(.N(PRI_LINES), .CH_W(CH_W)) u_chmap (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (map_we),
        .idx   (chan),
        .wdata (bus_wdata[CH_W-1:0]),
        .rdata (map_rd)
    );

    always_comb begin
        pend_word = '0;
        en_word   = '0;
        if (hi_word) begin
            pend_word[HI_LINES-1:0] = pri_pend[PRI_LINES-1:BUS_W];
            en_word[HI_LINES-1:0]   = pri_en[PRI_LINES-1:BUS_W];
        end else begin
            pend_word = pri_pend[BUS_W-1:0];
            en_word   = pri_en[BUS_W-1:0];
        end
        bus_rdata = '0;
        case (sel)
            SEL_PEND, SEL_ACK:     bus_rdata = pend_word;
            SEL_ENSET, SEL_ENCLR:  bus_rdata = en_word;
            SEL_INDEX:             bus_rdata[CI_W-1:0]      = prio_idx;
            SEL_SSTAT, SEL_SACK:   bus_rdata[SEC_LINES-1:0] = sec_pend;
            SEL_SENSET, SEL_SENCLR: bus_rdata[SEC_LINES-1:0] = sec_en;
            SEL_CHMAP:             bus_rdata[CH_W-1:0]      = map_rd;
            default:               bus_rdata = '0;
        endcase
    end

    // R1: state leaving reset is empty
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pri_pend == '0 && pri_en == '0 &&
                          sec_pend == '0 && sec_en == '0 && !cpu_irq));

    // R5: an active cascade reaches primary line 0 one edge later unless acked
    a_r5_cascade: assert property (@(posedge clk) disable iff (!rst_n)
        (cascade && !pri_ack[0]) |=> pri_pend[0]);

    // R6: a nonzero index names a requesting line with no lower one above 0
    a_r6_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_idx != '0) |-> (pri_req[prio_idx] &&
            ((pri_req & ((PRI_LINES'(1) << prio_idx) - PRI_LINES'(1))
                      & ~PRI_LINES'(1)) == '0)));

    a_r6_zero_means_none: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_idx == '0) |-> ((pri_req >> 1) == '0));

endmodule

// File: tb/casc_intc_tb.sv
module casc_intc_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [39:1] pri_src = '0;
    logic [31:0] sec_src = '0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cpu_irq;

    int nvec = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    casc_intc u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pri_src   (pri_src),
        .sec_src   (sec_src),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cpu_irq   (cpu_irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nvec++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic rchk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic pulse_pri(input logic [39:0] v);
        @(negedge clk);
        pri_src = v[39:1];
        @(negedge clk);
        pri_src = '0;
    endtask

    task automatic pulse_sec(input logic [31:0] v);
        @(negedge clk);
        sec_src = v;
        @(negedge clk);
        sec_src = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rchk("R1 pend lo", 12'h000, 32'h0);
        rchk("R1 pend hi", 12'h004, 32'h0);
        rchk("R1 en lo", 12'h020, 32'h0);
        rchk("R1 en hi", 12'h024, 32'h0);
        rchk("R1 index", 12'h040, 32'h0);
        rchk("R1 sec pend", 12'h080, 32'h0);
        rchk("R1 sec en", 12'h090, 32'h0);
        chk("R1 cpu_irq", {31'b0, cpu_irq}, 32'h0);
        for (int c = 0; c < 40; c++)
            rchk("R1 chmap identity", 12'h200 + 12'(4 * c), 32'(c));

        // R9 / R4: upper word width, set/clear readback, zero bits unchanged
        wr(12'h024, 32'hFFFF_FFFF);
        rchk("R9 en hi upper bits", 12'h024, 32'h0000_00FF);
        rchk("R4 en hi via clear addr", 12'h034, 32'h0000_00FF);
        wr(12'h034, 32'hFFFF_FFFF);
        rchk("R4 en hi cleared", 12'h024, 32'h0);
        wr(12'h020, 32'hFFFF_FFFF);
        wr(12'h030, 32'h0000_0001);
        rchk("R4 clear one bit", 12'h020, 32'hFFFF_FFFE);
        wr(12'h020, 32'h0);
        rchk("R4 zero set no effect", 12'h020, 32'hFFFF_FFFE);
        wr(12'h030, 32'h0);
        rchk("R4 zero clear no effect", 12'h030, 32'hFFFF_FFFE);
        wr(12'h030, 32'hFFFF_FFFF);
        rchk("R4 en lo cleared", 12'h020, 32'h0);

        // Per-line sweep over primary lines 1..39
        for (int i = 1; i < 40; i++) begin
            logic [39:0] e;
            logic [31:0] w;
            logic [11:0] off;
            e   = 40'(1) << i;
            w   = (i < 32) ? (32'(1) << i) : (32'(1) << (i - 32));
            off = (i < 32) ? 12'h000 : 12'h004;
            pulse_pri(e);
            rchk("R2 pend lo latched", 12'h000, e[31:0]);
            rchk("R2 pend hi latched", 12'h004, {24'b0, e[39:32]});
            chk("R7 disabled no irq", {31'b0, cpu_irq}, 32'h0);
            rchk("R6 disabled index 0", 12'h040, 32'h0);
            wr(12'h020 + off, w);
            rchk("R4 enable readback", 12'h020 + off, w);
            chk("R7 enabled irq", {31'b0, cpu_irq}, 32'h1);
            rchk("R6 single index", 12'h040, 32'(i));
            wr(12'h010 + off, w);
            rchk("R3 ack clears lo", 12'h000, 32'h0);
            rchk("R3 ack clears hi", 12'h004, 32'h0);
            chk("R7 acked no irq", {31'b0, cpu_irq}, 32'h0);
            wr(12'h030 + off, w);
            rchk("R4 disable readback", 12'h020 + off, 32'h0);
        end

        // R6: all pairs of primary lines, lowest number wins
        wr(12'h020, 32'hFFFF_FFFE);
        wr(12'h024, 32'h0000_00FF);
        for (int a = 1; a < 39; a++) begin
            for (int b = a + 1; b < 40; b++) begin
                pulse_pri((40'(1) << a) | (40'(1) << b));
                rchk("R6 pair index", 12'h040, 32'(a));
                chk("R7 pair irq", {31'b0, cpu_irq}, 32'h1);
                wr(12'h010, 32'hFFFF_FFFF);
                wr(12'h014, 32'h0000_00FF);
            end
        end

        // R3: acknowledge collides with a still-asserted source
        @(negedge clk);
        pri_src[5] = 1'b1;
        wr(12'h010, 32'h0000_0020);
        rchk("R3 collision lo cleared", 12'h000, 32'h0);
        @(negedge clk);
        rchk("R3 collision lo resets", 12'h000, 32'h0000_0020);
        pri_src[5] = 1'b0;
        wr(12'h010, 32'h0000_0020);
        rchk("R3 lo released", 12'h000, 32'h0);

        @(negedge clk);
        pri_src[35] = 1'b1;
        wr(12'h014, 32'h0000_0008);
        rchk("R3 collision hi cleared", 12'h004, 32'h0);
        @(negedge clk);
        rchk("R3 collision hi resets", 12'h004, 32'h0000_0008);
        pri_src[35] = 1'b0;
        wr(12'h014, 32'hFFFF_FF00);
        rchk("R9 upper ack bits ignored", 12'h004, 32'h0000_0008);
        wr(12'h014, 32'h0000_0008);
        rchk("R3 hi released", 12'h004, 32'h0);

        // R5: cascade sweep over secondary lines
        wr(12'h030, 32'hFFFF_FFFF);
        wr(12'h034, 32'h0000_00FF);
        wr(12'h020, 32'h0000_0001);
        for (int j = 0; j < 32; j++) begin
            logic [31:0] s;
            s = 32'(1) << j;
            pulse_sec(s);
            rchk("R2 sec latched", 12'h080, s);
            @(negedge clk);
            rchk("R5 disabled no cascade", 12'h000, 32'h0);
            chk("R5 disabled no irq", {31'b0, cpu_irq}, 32'h0);
            wr(12'h090, s);
            rchk("R4 sec enable readback", 12'h098, s);
            rchk("R5 cascade one edge late", 12'h000, 32'h0);
            chk("R5 no irq before cascade", {31'b0, cpu_irq}, 32'h0);
            @(negedge clk);
            rchk("R5 cascade latched", 12'h000, 32'h1);
            chk("R7 cascade irq", {31'b0, cpu_irq}, 32'h1);
            rchk("R6 cascade index 0", 12'h040, 32'h0);
            wr(12'h088, s);
            rchk("R3 sec ack", 12'h080, 32'h0);
            rchk("R5 line 0 stays latched", 12'h000, 32'h1);
            wr(12'h010, 32'h0000_0001);
            rchk("R3 line 0 ack", 12'h000, 32'h0);
            chk("R7 cascade cleared", {31'b0, cpu_irq}, 32'h0);
            wr(12'h098, s);
            rchk("R4 sec disable", 12'h090, 32'h0);
        end

        // R3: secondary collision
        @(negedge clk);
        sec_src[7] = 1'b1;
        wr(12'h088, 32'h0000_0080);
        rchk("R3 sec collision cleared", 12'h080, 32'h0);
        @(negedge clk);
        rchk("R3 sec collision resets", 12'h080, 32'h0000_0080);
        sec_src[7] = 1'b0;
        wr(12'h088, 32'h0000_0080);
        rchk("R3 sec released", 12'h080, 32'h0);

        // R8: channel map write and read, upper bits, out of range
        for (int c = 0; c < 40; c++)
            wr(12'h200 + 12'(4 * c), 32'hFFFF_FFC0 | 32'(39 - c));
        for (int c = 0; c < 40; c++)
            rchk("R8 chmap readback", 12'h200 + 12'(4 * c), 32'(39 - c));
        wr(12'h2A0, 32'h0000_0005);
        rchk("R8 past last entry", 12'h2A0, 32'h0);
        rchk("R8 entry 0 untouched", 12'h200, 32'd39);
        wr(12'h200, 32'h0000_003F);
        rchk("R8 full width", 12'h200, 32'h0000_003F);
        rchk("R9 unmapped", 12'h050, 32'h0);
        rchk("R9 unaligned", 12'h001, 32'h0);
        rchk("R6 index upper bits", 12'h040, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule